// File: doc/BRIEF.md
# Signed-Count Shift and Rotate Unit

This block moves the bits of a data word by an amount carried in a single two's-complement count. The sign of the count picks the direction: a positive count moves bits toward the most significant end ("left"), a negative count toward the least significant end ("right"). The magnitude gives the distance. Three operations are offered: a logical shift that fills with zeros, a rotate that wraps bits around, and an arithmetic shift that treats the top bit as a sign.

A mode input picks the operand width. In narrow mode the operand is 16 bits. In wide mode it is a 32-bit double word whose sign is bit 31. Counts larger than the word can hold give defined results, not wrapped ones. The datapath itself is combinational. Its result is captured in one output register, so a result appears one clock after its operands.

Top module: `sc_shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes zero. Otherwise `result` at each rising edge holds the outcome for the inputs present at that edge, so it is visible one cycle after the operands.
- R2: A count of zero returns the operand unchanged for every operation and both widths. A positive count moves bits toward the most significant bit, and a negative count moves them toward the least significant bit.
- R3: Logical shift is selected by `op_sel` = 2'b00, and also by the spare code 2'b11. It fills every vacated position with zero in both directions.
- R4: For a logical shift whose count magnitude exceeds W-1, the result is all zeros. W is 16 in narrow mode and 32 in wide mode.
- R5: Rotate is selected by `op_sel` = 2'b01. It moves the operand by the count magnitude modulo W, and the bits that leave one end re-enter at the other. A count of +W or -W returns the operand unchanged.
- R6: Arithmetic shift is selected by `op_sel` = 2'b10. With a negative count it copies the sign bit (bit W-1) into the vacated high positions. A magnitude above W-1 gives a word made entirely of the sign bit.
- R7: Arithmetic shift with a positive count keeps bit W-1 unchanged and shifts only bits W-2..0, filling with zeros. A magnitude above W-1 leaves only the sign bit, with all other bits zero.
- R8: With `wide` = 0, only `data_in[15:0]` is used, bits 31..16 of `data_in` have no effect, and `result[31:16]` is zero. With `wide` = 1, all 32 bits are the operand.
- R9: The most negative count, 16'h8000, is treated as a magnitude of 32768 to the right. It is therefore out of range for every width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00/11 logical shift, 01 rotate, 10 arithmetic shift |
| wide | input | 1 | 0: 16-bit operand, 1: 32-bit operand |
| data_in | input | 32 | Operand; only bits 15..0 used in narrow mode |
| shift_cnt | input | 16 | Signed count; sign selects direction, magnitude the distance |
| result | output | 32 | Registered result |

## Verification
Two effects can meet in a single operation: a change of direction and an out-of-range magnitude. Arithmetic shift is where they interact, because the out-of-range behaviour differs by sign (a full sign word to the right, the sign bit alone to the left). Rotate must not saturate at the same boundary at all. The bench provokes this with counts around ±(W-1), ±W, the extreme positive count and 16'h8000, for every operation in both widths, and adds a long random mix. Every cycle's registered output is judged against a bit-by-bit reference model. A second case is reset falling in the same cycle that an operation is presented: the bench expects zero for that cycle and the operation's result one cycle after release.

// File: rtl/sc_shift_pkg.sv
package sc_shift_pkg;

  // Operation codes seen on op_sel
  typedef enum logic [1:0] {
    OP_LSH  = 2'b00,
    OP_ROT  = 2'b01,
    OP_ASH  = 2'b10,
    OP_LSH2 = 2'b11
  } shop_e;

endpackage

// File: rtl/sc_count_decode.sv
// Splits a two's-complement count into direction and unsigned magnitude.
module sc_count_decode #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             go_left,
  output logic [CNT_W:0]   mag
);

  logic neg;

  assign neg     = cnt[CNT_W-1];
  assign go_left = !neg;

  // One extra bit so the most negative count keeps its full magnitude
  always_comb begin
    if (neg) mag = {1'b0, ~cnt} + 1'b1;
    else     mag = {1'b0, cnt};
  end

endmodule

// File: rtl/sc_barrel.sv
// Logarithmic barrel stage chain, one direction per instance.
module sc_barrel #(
  parameter int W      = 16,
  parameter bit TO_MSB = 1'b1
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  input  logic                 rot,
  input  logic                 fill,
  output logic [W-1:0]         dout
);

  localparam int LOG = $clog2(W);

  logic [W-1:0] stg [0:LOG];

  assign stg[0] = din;

  for (genvar i = 0; i < LOG; i++) begin : g_stage
    localparam int S = 1 << i;
    if (TO_MSB) begin : g_left
      assign stg[i+1] = !amt[i] ? stg[i] :
                        rot     ? {stg[i][W-1-S:0], stg[i][W-1:W-S]} :
                                  {stg[i][W-1-S:0], {S{fill}}};
    end else begin : g_right
      assign stg[i+1] = !amt[i] ? stg[i] :
                        rot     ? {stg[i][S-1:0], stg[i][W-1:S]} :
                                  {{S{fill}}, stg[i][W-1:S]};
    end
  end

  assign dout = stg[LOG];

endmodule

// File: rtl/sc_shift_lane.sv
// Full operation set for one operand width.
module sc_shift_lane
  import sc_shift_pkg::*;
#(
  parameter int W     = 16,
  parameter int MAG_W = 17
) (
  input  logic [W-1:0]     din,
  input  shop_e            op,
  input  logic             go_left,
  input  logic [MAG_W-1:0] mag,
  output logic [W-1:0]     dout
);

  localparam int               LOG     = $clog2(W);
  localparam logic [MAG_W-1:0] MAX_AMT = MAG_W'(W - 1);

  logic           over;
  logic [LOG-1:0] amt;
  logic           sgn;
  logic           rot;
  logic           rfill;
  logic [W-1:0]   lres;
  logic [W-1:0]   rres;

  assign over  = mag > MAX_AMT;
  assign amt   = mag[LOG-1:0];     // modulo W for rotate, exact otherwise
  assign sgn   = din[W-1];
  assign rot   = (op == OP_ROT);
  assign rfill = (op == OP_ASH) & sgn;

  sc_barrel #(.W(W), .TO_MSB(1'b1)) u_left (
    .din (din),
    .amt (amt),
    .rot (rot),
    .fill(1'b0),
    .dout(lres)
  );

  sc_barrel #(.W(W), .TO_MSB(1'b0)) u_right (
    .din (din),
    .amt (amt),
    .rot (rot),
    .fill(rfill),
    .dout(rres)
  );

  always_comb begin
    unique case (op)
      OP_ROT: dout = go_left ? lres : rres;
      OP_ASH: begin
        if (go_left) dout = over ? {sgn, {(W-1){1'b0}}} : {sgn, lres[W-2:0]};
        else         dout = over ? {W{sgn}} : rres;
      end
      default: begin
        if (over)         dout = '0;
        else if (go_left) dout = lres;
        else              dout = rres;
      end
    endcase
  end

endmodule

// File: rtl/sc_shift_unit.sv
// Signed-count shift/rotate unit with registered result.
module sc_shift_unit
  import sc_shift_pkg::*;
#(
  parameter int NW    = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_sel,
  input  logic              wide,
  input  logic [2*NW-1:0]   data_in,
  input  logic [CNT_W-1:0]  shift_cnt,
  output logic [2*NW-1:0]   result
);

  localparam int WW    = 2 * NW;
  localparam int MAG_W = CNT_W + 1;

  shop_e            op;
  logic             go_left;
  logic [MAG_W-1:0] mag;
  logic [NW-1:0]    nres;
  logic [WW-1:0]    wres;
  logic [WW-1:0]    res_d;

  assign op = shop_e'(op_sel);

  sc_count_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt    (shift_cnt),
    .go_left(go_left),
    .mag    (mag)
  );

  sc_shift_lane #(.W(NW), .MAG_W(MAG_W)) u_narrow (
    .din    (data_in[NW-1:0]),
    .op     (op),
    .go_left(go_left),
    .mag    (mag),
    .dout   (nres)
  );

  sc_shift_lane #(.W(WW), .MAG_W(MAG_W)) u_wide (
    .din    (data_in),
    .op     (op),
    .go_left(go_left),
    .mag    (mag),
    .dout   (wres)
  );

  assign res_d = wide ? wres : {{NW{1'b0}}, nres};

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= res_d;
  end

endmodule

// File: rtl/sc_shift_unit_chk.sv
// Temporal checks on the shift unit's ports.
module sc_shift_unit_chk #(
  parameter int NW    = 16,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_sel,
  input logic              wide,
  input logic [2*NW-1:0]   data_in,
  input logic [CNT_W-1:0]  shift_cnt,
  input logic [2*NW-1:0]   result
);

  localparam int WW = 2 * NW;

  logic                    armed;
  logic signed [CNT_W-1:0] cnt_s;
  logic                    narrow_over;
  logic [WW-1:0]           opnd;
  logic                    sign_in;
  logic                    sign_out;
  logic                    was_wide;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_ff @(posedge clk) was_wide <= wide;

  assign cnt_s       = $signed(shift_cnt);
  assign narrow_over = (cnt_s > (NW - 1)) || (cnt_s < -(NW - 1));
  assign opnd        = wide ? data_in : {{NW{1'b0}}, data_in[NW-1:0]};
  assign sign_in     = wide ? data_in[WW-1] : data_in[NW-1];
  assign sign_out    = was_wide ? result[WW-1] : result[NW-1];

  p_zero_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(shift_cnt) == '0) |-> result == $past(opnd));

  p_lsh_over_r4: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(wide) && $past(narrow_over) &&
    (($past(op_sel) == 2'b00) || ($past(op_sel) == 2'b11)) |-> result == '0);

  p_rot_ones_r5: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(op_sel) == 2'b01) |-> $countones(result) == $past($countones(opnd)));

  p_ash_sign_r7: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(op_sel) == 2'b10) |-> sign_out == $past(sign_in));

  p_narrow_top_r8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(wide) |-> result[WW-1:NW] == '0);

endmodule

bind sc_shift_unit sc_shift_unit_chk #(.NW(NW), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_sel   (op_sel),
  .wide     (wide),
  .data_in  (data_in),
  .shift_cnt(shift_cnt),
  .result   (result)
);

// File: tb/sc_shift_unit_bench.sv
module sc_shift_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_sel = 2'b00;
  logic        wide = 1'b0;
  logic [31:0] data_in = '0;
  logic [15:0] shift_cnt = '0;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;   // 125 MHz

  sc_shift_unit u_sc_shift_unit (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .wide     (wide),
    .data_in  (data_in),
    .shift_cnt(shift_cnt),
    .result   (result)
  );

  // Behavioural reference: builds each output bit from its source position
  function automatic logic [31:0] ref_calc(logic [1:0] op, logic wd,
                                           logic [31:0] d, logic [15:0] c);
    int          w;
    int          ci;
    int          mag;
    int          s;
    int          k;
    logic        sg;
    logic        b;
    logic [31:0] r;
    w   = wd ? 32 : 16;
    ci  = $signed(c);
    mag = (ci < 0) ? -ci : ci;
    sg  = d[w-1];
    r   = '0;
    for (int i = 0; i < w; i++) begin
      case (op)
        2'b01: begin
          k = mag % w;
          s = (ci >= 0) ? (i - k + w) % w : (i + k) % w;
          b = d[s];
        end
        2'b10: begin
          if (ci >= 0) begin
            if (i == w - 1) b = sg;
            else begin
              s = i - mag;
              b = (s >= 0) ? d[s] : 1'b0;
            end
          end else begin
            s = i + mag;
            b = (s < w) ? d[s] : sg;
          end
        end
        default: begin
          if (ci >= 0) begin
            s = i - mag;
            b = (s >= 0) ? d[s] : 1'b0;
          end else begin
            s = i + mag;
            b = (s < w) ? d[s] : 1'b0;
          end
        end
      endcase
      r[i] = b;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, judge at the next falling edge (one register)
  task automatic apply(string tag, logic [1:0] op, logic wd,
                       logic [31:0] d, logic [15:0] c);
    logic [31:0] exp;
    op_sel    = op;
    wide      = wd;
    data_in   = d;
    shift_cnt = c;
    exp       = ref_calc(op, wd, d, c);
    @(negedge clk);
    check(tag, result, exp);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset holds result at zero even with an operation presented
    op_sel    = 2'b01;
    wide      = 1'b1;
    data_in   = 32'hDEAD_BEEF;
    shift_cnt = 16'd3;
    repeat (3) @(negedge clk);
    check("R1 reset", result, 32'h0);
    rst = 1'b0;
    apply("R1 first after release", 2'b01, 1'b1, 32'hDEAD_BEEF, 16'd3);

    // R2: zero count passes through, direction from sign
    apply("R2 zero lsh", 2'b00, 1'b0, 32'h0000_A5C3, 16'd0);
    apply("R2 zero rot", 2'b01, 1'b1, 32'h8123_4567, 16'd0);
    apply("R2 zero ash", 2'b10, 1'b0, 32'h0000_8001, 16'd0);
    apply("R2 left", 2'b00, 1'b0, 32'h0000_0001, 16'd4);
    apply("R2 right", 2'b00, 1'b0, 32'h0000_8000, 16'hFFFC);

    // R3: logical zero fill, both codes
    apply("R3 lsh left", 2'b00, 1'b0, 32'h0000_FFFF, 16'd5);
    apply("R3 lsh right", 2'b00, 1'b0, 32'h0000_FFFF, 16'hFFFB);
    apply("R3 spare code", 2'b11, 1'b1, 32'hFFFF_FFFF, 16'hFFF0);
    apply("R3 edge 15", 2'b00, 1'b0, 32'h0000_0001, 16'd15);

    // R4: over-range logical
    apply("R4 narrow +16", 2'b00, 1'b0, 32'h0000_FFFF, 16'd16);
    apply("R4 narrow -16", 2'b11, 1'b0, 32'h0000_FFFF, 16'hFFF0);
    apply("R4 wide +32", 2'b00, 1'b1, 32'hFFFF_FFFF, 16'd32);
    apply("R4 wide 31", 2'b00, 1'b1, 32'h0000_0001, 16'd31);
    apply("R4 max pos", 2'b00, 1'b0, 32'h0000_1234, 16'h7FFF);

    // R5: rotate modulo width
    apply("R5 rot +16", 2'b01, 1'b0, 32'h0000_1234, 16'd16);
    apply("R5 rot -16", 2'b01, 1'b0, 32'h0000_1234, 16'hFFF0);
    apply("R5 rot +4", 2'b01, 1'b0, 32'h0000_F001, 16'd4);
    apply("R5 rot -1", 2'b01, 1'b1, 32'h0000_0001, 16'hFFFF);
    apply("R5 rot +33", 2'b01, 1'b1, 32'h8000_0000, 16'd33);
    apply("R5 rot -32", 2'b01, 1'b1, 32'h1234_5678, 16'hFFE0);

    // R6: arithmetic right
    apply("R6 ash right neg", 2'b10, 1'b0, 32'h0000_8000, 16'hFFFD);
    apply("R6 ash right pos", 2'b10, 1'b0, 32'h0000_7000, 16'hFFFD);
    apply("R6 ash over", 2'b10, 1'b0, 32'h0000_8000, 16'hFFEF);
    apply("R6 ash wide", 2'b10, 1'b1, 32'h8000_0000, 16'hFFE1);

    // R7: arithmetic left keeps the sign
    apply("R7 ash left neg", 2'b10, 1'b0, 32'h0000_C001, 16'd1);
    apply("R7 ash left pos", 2'b10, 1'b0, 32'h0000_4001, 16'd2);
    apply("R7 ash left over", 2'b10, 1'b0, 32'h0000_FFFF, 16'd16);
    apply("R7 ash wide over", 2'b10, 1'b1, 32'hFFFF_FFFF, 16'd40);

    // R8: narrow mode ignores the upper operand half
    apply("R8 upper ignored", 2'b01, 1'b0, 32'hFFFF_0F0F, 16'd4);
    apply("R8 upper ignored ash", 2'b10, 1'b0, 32'hABCD_0001, 16'hFFFF);
    apply("R8 wide uses all", 2'b00, 1'b1, 32'h0001_0000, 16'hFFFF);

    // R9: most negative count
    apply("R9 lsh min", 2'b00, 1'b1, 32'hFFFF_FFFF, 16'h8000);
    apply("R9 ash min", 2'b10, 1'b0, 32'h0000_8000, 16'h8000);
    apply("R9 rot min", 2'b01, 1'b0, 32'h0000_1234, 16'h8000);

    // Random mix, counts biased toward the interesting range
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  op;
      logic        wd;
      logic [31:0] d;
      logic [15:0] c;
      string       tag;
      op = 2'($urandom);
      wd = 1'($urandom);
      d  = $urandom;
      c  = ($urandom % 4 == 0) ? 16'($urandom) : 16'(int'($urandom % 81) - 40);
      if (op == 2'b01)      tag = "R5 random rot";
      else if (op == 2'b10) tag = c[15] ? "R6 random ash" : "R7 random ash";
      else                  tag = "R3 random lsh";
      apply(tag, op, wd, d, c);
    end

    // R1: reset arriving with an operation, then release
    rst = 1'b1;
    apply("R1 reset mid-run", 2'b00, 1'b0, 32'h0, 16'd0);
    data_in = 32'h0000_00FF;
    @(negedge clk);
    check("R1 reset mid-run hold", result, 32'h0);
    rst = 1'b0;
    apply("R1 after second release", 2'b00, 1'b0, 32'h0000_00FF, 16'd8);

    summary();
    $finish;
  end

endmodule